// File: doc/BRIEF.md
# Flash Mode-Dependent Read Responder

This block is the read half of an emulated parallel NOR flash that uses the classic unlock-and-command protocol. A separate command sequencer tracks the write cycles and presents its current mode code. On each bus read, this block picks the data source from that code. The choices are array contents, identification words, a polled status byte, or an entry of the self-describing query table. The result comes back one clock later, together with a valid strobe.

The bus is 1, 2 or 4 bytes wide. The storage is a small byte-addressed memory inside the block. It comes out of reset holding a computed pattern, and the program path of the sequencer overwrites it one byte at a time through a fill port. The status byte is loaded by the sequencer when a program or erase starts. Every status read inverts bit 6, so software that polls for the toggle sees the operation still running until the sequencer changes the mode. The identification words and the tunable query entries are parameters.

Top module: `flash_read_resp`

## Requirements
- R1: While reset is asserted and after its release, `rvalid_o` and `mode_clr_o` are 0, `rdata_o` is 0, and the stored status byte is 0x00.
- R2: A read on `rd_i` at clock edge k drives `rdata_o` and a one-cycle `rvalid_o` pulse after edge k. Without a read, `rvalid_o` is 0 after the edge.
- R3: In mode 0x00 (read) and mode 0x80 (erase setup), a read returns array bytes at the byte address aligned down to the bus width. Byte lane i carries byte base+i when BIG_ENDIAN=0, and lane BUS_BYTES-1-i carries it when BIG_ENDIAN=1. After reset, array byte n holds (7*n + INIT_SEED) mod 256.
- R4: The lookup offset for identification and query reads is address bits [7:0] shifted right by log2(BUS_BYTES). Higher address bits are ignored.
- R5: In mode 0x90 (autoselect), offset 0 returns ID0 and offset 1 returns ID1, zero-extended or truncated to the bus width.
- R6: In autoselect mode, offset 2 returns 0, which reports every sector as unprotected.
- R7: In autoselect mode, offsets 0x0E and 0x0F return ID2 and ID3. If that word is 16'hFFFF, the read returns array data instead.
- R8: Every other autoselect offset returns array data.
- R9: In modes 0xA0, 0x10 and 0x30, a read returns the status byte zero-extended. Bit 6 of the stored status then inverts, and the other bits hold. Reads in other modes leave the status unchanged.
- R10: `stat_ld_i` loads `stat_i` into the status byte at the clock edge. When a load and a status read happen in the same cycle, the read returns the old value and the load wins.
- R11: In mode 0x98 (query), offsets 0x10 to 0x12 return 0x51, 0x52 and 0x59 ("QRY"). Offset 0x13 returns 0x02 and 0x14 returns 0x00 (command set 2). Offsets 0x1B, 0x1C and 0x1F return QRY_VMIN, QRY_VMAX and QRY_TMO. All other offsets up to 0x52 return 0.
- R12: In query mode, an offset above 0x52 returns 0.
- R13: A read with any other mode code returns array data. It also pulses `mode_clr_o` together with `rvalid_o`, so the sequencer returns to read mode.
- R14: `fill_en_i` writes `fill_data_i` into array byte `fill_addr_i`, and later array reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | $clog2(ARR_BYTES) | Byte address of the read |
| mode_i | input | 8 | Current mode code from the sequencer |
| stat_ld_i | input | 1 | Load the status byte |
| stat_i | input | 8 | Status value to load |
| fill_en_i | input | 1 | Array byte write enable |
| fill_addr_i | input | $clog2(ARR_BYTES) | Array byte write address |
| fill_data_i | input | 8 | Array byte write data |
| rdata_o | output | 8*BUS_BYTES | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle |
| mode_clr_o | output | 1 | Unknown mode seen; return to read mode |

## Verification
The hardest case to reach is a status load that lands in the same cycle as a status poll. Here the returned byte, the load and the toggle all meet on one edge. The bench drives `stat_ld_i` and `rd_i` together in erase mode. It then polls twice, which separates "load wins" from "toggle applied on top". Identification fallback also needs care: the default ID3 is all ones, so the offset 0x0F read must match array bytes, while offset 0x0E must still return the word. A prior array fill makes the fallback data distinct.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam logic [7:0] MD_READ    = 8'h00;
  localparam logic [7:0] MD_ESETUP  = 8'h80;
  localparam logic [7:0] MD_AUTOSEL = 8'h90;
  localparam logic [7:0] MD_PROG    = 8'hA0;
  localparam logic [7:0] MD_CERASE  = 8'h10;
  localparam logic [7:0] MD_SERASE  = 8'h30;
  localparam logic [7:0] MD_QUERY   = 8'h98;
  localparam logic [7:0] QRY_LAST   = 8'h52;

  typedef enum logic [2:0] {
    SRC_ARR, SRC_ID, SRC_STAT, SRC_QRY
  } src_e;

  function automatic logic [7:0] qry_byte(input logic [7:0] off,
                                          input logic [7:0] vmin,
                                          input logic [7:0] vmax,
                                          input logic [7:0] tmo);
    logic [7:0] r;
    case (off)
      8'h10:   r = 8'h51;
      8'h11:   r = 8'h52;
      8'h12:   r = 8'h59;
      8'h13:   r = 8'h02;
      8'h1B:   r = vmin;
      8'h1C:   r = vmax;
      8'h1F:   r = tmo;
      default: r = 8'h00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/flash_arr.sv
module flash_arr #(
  parameter int BUS_BYTES = 2,
  parameter int ARR_BYTES = 512,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter logic [7:0] INIT_SEED = 8'h3C,
  localparam int ADDR_W = $clog2(ARR_BYTES),
  localparam int DW = 8 * BUS_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fill_en_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [7:0]        fill_data_i,
  output logic [DW-1:0]     data_o
);
  logic [7:0] mem_q [ARR_BYTES];
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARR_BYTES; i++) mem_q[i] <= 8'(i * 7) + INIT_SEED;
    end else if (fill_en_i) begin
      mem_q[fill_addr_i] <= fill_data_i;
    end
  end

  assign base = addr_i & ~ADDR_W'(BUS_BYTES - 1);

  for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
    if (BIG_ENDIAN) begin : g_be
      assign data_o[8*(BUS_BYTES-1-l) +: 8] = mem_q[base + ADDR_W'(l)];
    end else begin : g_le
      assign data_o[8*l +: 8] = mem_q[base + ADDR_W'(l)];
    end
  end
endmodule

// File: rtl/flash_lookup.sv
module flash_lookup #(
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h227E,
  parameter logic [15:0] ID2 = 16'h2223,
  parameter logic [15:0] ID3 = 16'hFFFF,
  parameter logic [7:0]  QRY_VMIN = 8'h27,
  parameter logic [7:0]  QRY_VMAX = 8'h36,
  parameter logic [7:0]  QRY_TMO  = 8'h07
) (
  input  logic [7:0]  off_i,
  output logic        id_hit_o,
  output logic [15:0] id_word_o,
  output logic [7:0]  qry_o
);
  import flash_rd_pkg::*;

  always_comb begin
    id_hit_o  = 1'b1;
    id_word_o = 16'h0000;
    case (off_i)
      8'h00: id_word_o = ID0;
      8'h01: id_word_o = ID1;
      8'h02: id_word_o = 16'h0000;
      8'h0E: begin id_word_o = ID2; id_hit_o = (ID2 != 16'hFFFF); end
      8'h0F: begin id_word_o = ID3; id_hit_o = (ID3 != 16'hFFFF); end
      default: id_hit_o = 1'b0;
    endcase
  end

  assign qry_o = (off_i > QRY_LAST) ? 8'h00
               : qry_byte(off_i, QRY_VMIN, QRY_VMAX, QRY_TMO);
endmodule

// File: rtl/flash_status.sv
module flash_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic       rd_i,
  output logic [7:0] stat_o
);
  logic [7:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= 8'h00;
    else if (ld_i)  stat_q <= ld_val_i;
    else if (rd_i)  stat_q <= stat_q ^ 8'h40;
  end

  assign stat_o = stat_q;

  AST_STAT_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !ld_i |=> stat_q[6] != $past(stat_q[6])); // R9
  AST_STAT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !ld_i |=> stat_q[7] == $past(stat_q[7]) && stat_q[5:0] == $past(stat_q[5:0])); // R9
  AST_STAT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i && !ld_i |=> $stable(stat_q)); // R9
  AST_STAT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> stat_q == $past(ld_val_i)); // R10
endmodule

// File: rtl/flash_read_resp.sv
module flash_read_resp #(
  parameter int BUS_BYTES = 2,
  parameter int ARR_BYTES = 512,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter logic [7:0]  INIT_SEED = 8'h3C,
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h227E,
  parameter logic [15:0] ID2 = 16'h2223,
  parameter logic [15:0] ID3 = 16'hFFFF,
  parameter logic [7:0]  QRY_VMIN = 8'h27,
  parameter logic [7:0]  QRY_VMAX = 8'h36,
  parameter logic [7:0]  QRY_TMO  = 8'h07
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_i,
  input  logic [$clog2(ARR_BYTES)-1:0] addr_i,
  input  logic [7:0]                   mode_i,
  input  logic                         stat_ld_i,
  input  logic [7:0]                   stat_i,
  input  logic                         fill_en_i,
  input  logic [$clog2(ARR_BYTES)-1:0] fill_addr_i,
  input  logic [7:0]                   fill_data_i,
  output logic [8*BUS_BYTES-1:0]       rdata_o,
  output logic                         rvalid_o,
  output logic                         mode_clr_o
);
  import flash_rd_pkg::*;

  localparam int DW = 8 * BUS_BYTES;
  localparam int SHIFT = $clog2(BUS_BYTES);

  logic [7:0]    off;
  logic [DW-1:0] arr_data;
  logic          id_hit;
  logic [15:0]   id_word;
  logic [7:0]    qry;
  logic [7:0]    stat;
  src_e          src;
  logic          unknown;
  logic [DW-1:0] rdata_d;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q, clr_q;

  assign off = addr_i[7:0] >> SHIFT;

  flash_arr #(
    .BUS_BYTES(BUS_BYTES), .ARR_BYTES(ARR_BYTES),
    .BIG_ENDIAN(BIG_ENDIAN), .INIT_SEED(INIT_SEED)
  ) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .fill_en_i(fill_en_i), .fill_addr_i(fill_addr_i), .fill_data_i(fill_data_i),
    .data_o(arr_data)
  );

  flash_lookup #(
    .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3),
    .QRY_VMIN(QRY_VMIN), .QRY_VMAX(QRY_VMAX), .QRY_TMO(QRY_TMO)
  ) u_lkp (
    .off_i(off), .id_hit_o(id_hit), .id_word_o(id_word), .qry_o(qry)
  );

  flash_status u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ld_i(stat_ld_i), .ld_val_i(stat_i),
    .rd_i(rd_i && src == SRC_STAT),
    .stat_o(stat)
  );

  always_comb begin
    unknown = 1'b0;
    case (mode_i)
      MD_READ, MD_ESETUP:           src = SRC_ARR;
      MD_AUTOSEL:                   src = id_hit ? SRC_ID : SRC_ARR;
      MD_PROG, MD_CERASE, MD_SERASE: src = SRC_STAT;
      MD_QUERY:                     src = SRC_QRY;
      default: begin
        src = SRC_ARR;
        unknown = 1'b1;
      end
    endcase
  end

  always_comb begin
    case (src)
      SRC_ID:   rdata_d = DW'(id_word);
      SRC_STAT: rdata_d = DW'(stat);
      SRC_QRY:  rdata_d = DW'(qry);
      default:  rdata_d = arr_data;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      clr_q    <= rd_i && unknown;
      if (rd_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;
  assign mode_clr_o = clr_q;

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o); // R2
  AST_CLR_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_clr_o |-> rvalid_o); // R13
  AST_PROT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && mode_i == MD_AUTOSEL && off == 8'h02 |=> rdata_o == '0); // R6
  AST_QRY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && mode_i == MD_QUERY && off > QRY_LAST |=> rdata_o == '0); // R12
endmodule

// File: tb/sim_flash_read_resp.sv
module sim_flash_read_resp;
  localparam logic [7:0] SEED = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0;
  logic [8:0]  addr_i = '0;
  logic [7:0]  mode_i = '0;
  logic        stat_ld_i = 1'b0;
  logic [7:0]  stat_i = '0;
  logic        fill_en_i = 1'b0;
  logic [8:0]  fill_addr_i = '0;
  logic [7:0]  fill_data_i = '0;
  logic [15:0] rdata_o;
  logic        rvalid_o, mode_clr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_read_resp u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .addr_i(addr_i), .mode_i(mode_i),
    .stat_ld_i(stat_ld_i), .stat_i(stat_i), .fill_en_i(fill_en_i),
    .fill_addr_i(fill_addr_i), .fill_data_i(fill_data_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .mode_clr_o(mode_clr_o)
  );

  function automatic logic [7:0] init_b(input int n);
    return 8'(n * 7) + SEED;
  endfunction

  function automatic logic [15:0] init_w(input int a);
    int b = a & ~1;
    return {init_b(b + 1), init_b(b)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one read; result sampled at the falling edge after the capturing edge
  task automatic rd(input logic [8:0] a, input logic [7:0] m,
                    output logic [15:0] d, output logic clr);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a; mode_i = m;
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o; clr = mode_clr_o;
    chk("R2 valid", {31'd0, rvalid_o}, 32'd1);
  endtask

  task automatic fill(input logic [8:0] a, input logic [7:0] v);
    @(negedge clk);
    fill_en_i = 1'b1; fill_addr_i = a; fill_data_i = v;
    @(negedge clk);
    fill_en_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rvalid", {31'd0, rvalid_o}, 0);
    chk("R1 clr", {31'd0, mode_clr_o}, 0);
    chk("R1 rdata", {16'd0, rdata_o}, 0);
    @(negedge clk);
    chk("R2 idle", {31'd0, rvalid_o}, 0);
  endtask

  task automatic t_array;
    logic [15:0] d; logic c;
    rd(9'h010, 8'h00, d, c); chk("R3 read", {16'd0, d}, {16'd0, init_w(16)});
    chk("R13 clr quiet", {31'd0, c}, 0);
    rd(9'h103, 8'h80, d, c); chk("R3 esetup unaligned", {16'd0, d}, {16'd0, init_w(9'h102)});
    rd(9'h1FE, 8'h00, d, c); chk("R3 top", {16'd0, d}, {16'd0, init_w(9'h1FE)});
    @(negedge clk);
    chk("R2 pulse", {31'd0, rvalid_o}, 0);
  endtask

  task automatic t_fill;
    logic [15:0] d; logic c;
    fill(9'h040, 8'hA5);
    rd(9'h040, 8'h00, d, c); chk("R14 fill", {16'd0, d}, {16'd0, init_b(9'h41), 8'hA5});
    fill(9'h01F, 8'h5A);
  endtask

  task automatic t_autosel;
    logic [15:0] d; logic c;
    rd(9'h000, 8'h90, d, c); chk("R5 id0", {16'd0, d}, 32'h0001);
    rd(9'h002, 8'h90, d, c); chk("R5 id1", {16'd0, d}, 32'h227E);
    rd(9'h102, 8'h90, d, c); chk("R4 high bits", {16'd0, d}, 32'h227E);
    rd(9'h004, 8'h90, d, c); chk("R6 prot", {16'd0, d}, 32'h0000);
    rd(9'h104, 8'h90, d, c); chk("R4 prot high", {16'd0, d}, 32'h0000);
    rd(9'h01C, 8'h90, d, c); chk("R7 id2", {16'd0, d}, 32'h2223);
    rd(9'h01E, 8'h90, d, c); chk("R7 id3 fallback", {16'd0, d}, {16'd0, 8'h5A, init_b(9'h1E)});
    rd(9'h006, 8'h90, d, c); chk("R8 other", {16'd0, d}, {16'd0, init_w(6)});
  endtask

  task automatic t_status;
    logic [15:0] d; logic c;
    rd(9'h000, 8'hA0, d, c); chk("R9 first", {16'd0, d}, 32'h0000);
    rd(9'h000, 8'h10, d, c); chk("R9 toggle", {16'd0, d}, 32'h0040);
    rd(9'h000, 8'h00, d, c);
    rd(9'h000, 8'h30, d, c); chk("R9 no toggle in read", {16'd0, d}, 32'h0000);
    @(negedge clk); stat_ld_i = 1'b1; stat_i = 8'h7F;
    @(negedge clk); stat_ld_i = 1'b0;
    rd(9'h000, 8'hA0, d, c); chk("R10 load", {16'd0, d}, 32'h007F);
    rd(9'h000, 8'hA0, d, c); chk("R9 keep bits", {16'd0, d}, 32'h003F);
    // load collides with a poll
    @(negedge clk); stat_ld_i = 1'b1; stat_i = 8'h80; rd_i = 1'b1; mode_i = 8'h30;
    @(negedge clk); stat_ld_i = 1'b0; rd_i = 1'b0;
    chk("R10 old value", {16'd0, rdata_o}, 32'h007F);
    rd(9'h000, 8'h30, d, c); chk("R10 load wins", {16'd0, d}, 32'h0080);
    rd(9'h000, 8'h30, d, c); chk("R10 then toggle", {16'd0, d}, 32'h00C0);
  endtask

  task automatic t_query;
    logic [15:0] d; logic c;
    rd(9'h020, 8'h98, d, c); chk("R11 Q", {16'd0, d}, 32'h0051);
    rd(9'h022, 8'h98, d, c); chk("R11 R", {16'd0, d}, 32'h0052);
    rd(9'h024, 8'h98, d, c); chk("R11 Y", {16'd0, d}, 32'h0059);
    rd(9'h026, 8'h98, d, c); chk("R11 cmdset lo", {16'd0, d}, 32'h0002);
    rd(9'h028, 8'h98, d, c); chk("R11 cmdset hi", {16'd0, d}, 32'h0000);
    rd(9'h036, 8'h98, d, c); chk("R11 vmin", {16'd0, d}, 32'h0027);
    rd(9'h038, 8'h98, d, c); chk("R11 vmax", {16'd0, d}, 32'h0036);
    rd(9'h03E, 8'h98, d, c); chk("R11 tmo", {16'd0, d}, 32'h0007);
    rd(9'h000, 8'h98, d, c); chk("R11 low zero", {16'd0, d}, 32'h0000);
    rd(9'h0A6, 8'h98, d, c); chk("R12 beyond", {16'd0, d}, 32'h0000);
    rd(9'h0FE, 8'h98, d, c); chk("R12 end", {16'd0, d}, 32'h0000);
  endtask

  task automatic t_unknown;
    logic [15:0] d; logic c;
    rd(9'h012, 8'h55, d, c);
    chk("R13 data", {16'd0, d}, {16'd0, init_w(9'h12)});
    chk("R13 clr", {31'd0, c}, 1);
    @(negedge clk);
    chk("R13 clr pulse", {31'd0, mode_clr_o}, 0);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    t_reset;
    t_array;
    t_fill;
    t_autosel;
    t_status;
    t_query;
    t_unknown;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule